// File: doc/BRIEF.md
# Operand Address Decoder (ModR/M / SIB)

This block sits behind an instruction byte queue and turns the operand-addressing bytes of one instruction into a resolved operand description. It accepts the addressing-mode byte first. It then takes an optional scale-index-base byte and up to four displacement bytes, one byte per handshake. It reports the register-operand number and whether the second operand is a register or memory. For a memory operand it also reports the effective address and whether the stack segment should be used by default.

The address size (16 or 32 bit) and the segment-override-present flag are sampled together with the addressing-mode byte and apply to the whole decode. Base and index register values are fetched through two combinational read ports into the general register file. The ports are indexed 0..7 in the order AX, CX, DX, BX, SP, BP, SI, DI. The result registers are loaded on the clock edge that accepts the final byte. `done` pulses for one cycle after that edge, and the results hold until the next decode finishes.

Top module: `modrm_decoder`

## Requirements
- R1: The first byte is split as mode = bits 7:6, reg = bits 5:3, r/m = bits 2:0. Mode 3 gives `is_mem`=0, `rm_reg` = r/m, `eff_addr`=0, `use_stack`=0 and a byte count of 1.
- R2: For byte-sized operands, bit 2 of a register number sets the high-byte flag and bits 1:0 pick one of registers 0..3. This is output for both the reg and r/m fields.
- R3: In 32-bit mode with r/m not 4, a base register r/m is used. Mode 1 adds a sign-extended 8-bit displacement and mode 2 adds a 32-bit displacement, with 32-bit wraparound.
- R4: In 32-bit mode, r/m 5 with mode 0 yields a 32-bit displacement alone, with no register.
- R5: In 32-bit mode, r/m 4 (mode not 3) consumes a scale-index-base byte: scale = 1<<bits 7:6, index = bits 5:3, base = bits 2:0. An index of 4 contributes nothing.
- R6: A scale-index-base byte with base 5 and mode 0 replaces the base register with a 32-bit displacement.
- R7: In 32-bit mode without override, `use_stack` is 1 when the scale-index-base base is 4, or when r/m is 5 with a nonzero mode. An override forces it to 0.
- R8: In 16-bit mode, r/m selects from the low 16 bits of the registers: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX.
- R9: In 16-bit mode, mode 1 adds a sign-extended 8-bit displacement and mode 2 a sign-extended 16-bit one. r/m 6 with mode 0 is a 16-bit displacement alone. The address is truncated to 16 bits.
- R10: In 16-bit mode without override, `use_stack` is 1 for r/m 2 and 3, and for r/m 6 with a nonzero mode.
- R11: Displacement bytes are taken least significant first. `bytes_used` equals 1 + (scale-index-base byte present) + displacement length.
- R12: `done` is high exactly one cycle after the edge that accepts the final byte. Idle cycles between bytes are allowed, and results do not change while `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Instruction stream byte |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte accepted when valid |
| addr32 | input | 1 | 1 = 32-bit address size, sampled with first byte |
| seg_ovr | input | 1 | Segment override present, sampled with first byte |
| rd_idx_a | output | 3 | Base register read index |
| rd_data_a | input | 32 | Base register value |
| rd_idx_b | output | 3 | Index register read index |
| rd_data_b | input | 32 | Index register value |
| done | output | 1 | Decode complete pulse |
| reg_num | output | 3 | Register operand number |
| is_mem | output | 1 | Second operand is memory |
| rm_reg | output | 3 | r/m field (second register in register form) |
| eff_addr | output | 32 | Effective address |
| use_stack | output | 1 | Default segment is the stack segment |
| bytes_used | output | 3 | Bytes consumed by this decode |
| reg_byte_sel | output | 2 | Byte register for reg field |
| reg_byte_hi | output | 1 | reg field names a high byte |
| rm_byte_sel | output | 2 | Byte register for r/m field |
| rm_byte_hi | output | 1 | r/m field names a high byte |

## Verification
On every cycle, the assertions check several invariants. `done` only follows an accepted byte, and the results stay frozen between completions. A register-form result carries no address, stack flag or extra bytes, and the stack flag never accompanies a register form. A 16-bit result never has upper address bits set, and byte counts stay within 1..6. The arithmetic of each addressing form can only be shown by the bench's scenarios. This covers the table entries, the special base and index encodings, sign extension, 16-bit wrap, displacement byte order and override suppression, each against hand-computed addresses.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

    localparam int AW      = 32;
    localparam int NREGS   = 8;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int DMAX    = AW / 8;
    localparam int CNT_W   = 3;

    localparam logic [RIDX_W-1:0] R_AX = 3'd0;
    localparam logic [RIDX_W-1:0] R_BX = 3'd3;
    localparam logic [RIDX_W-1:0] R_SP = 3'd4;
    localparam logic [RIDX_W-1:0] R_BP = 3'd5;
    localparam logic [RIDX_W-1:0] R_SI = 3'd6;
    localparam logic [RIDX_W-1:0] R_DI = 3'd7;

    typedef struct packed {
        logic [1:0]        md;
        logic [RIDX_W-1:0] rf;
        logic [RIDX_W-1:0] rm;
    } modrm_t;

    typedef struct packed {
        logic [1:0]        ss;
        logic [RIDX_W-1:0] idx;
        logic [RIDX_W-1:0] base;
    } sib_t;

    typedef enum logic [1:0] {S_MODRM, S_SIB, S_DISP} seq_state_e;

    function automatic logic sib_needed(input logic a32, input modrm_t m);
        return a32 && (m.md != 2'd3) && (m.rm == R_SP);
    endfunction

    function automatic logic [CNT_W-1:0] disp_bytes(input logic a32, input modrm_t m,
                                                     input sib_t s);
        logic [CNT_W-1:0] n;
        n = '0;
        case (m.md)
            2'd1: n = 3'd1;
            2'd2: n = a32 ? 3'd4 : 3'd2;
            2'd0: begin
                if (a32) begin
                    if (m.rm == R_BP || (m.rm == R_SP && s.base == R_BP)) n = 3'd4;
                end else if (m.rm == R_SI) begin
                    n = 3'd2;
                end
            end
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/modrm_seq.sv
module modrm_seq
    import modrm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       in_byte,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             addr32,
    input  logic             seg_ovr,
    output logic             fin,
    output modrm_t           mb,
    output sib_t             sb,
    output logic             a32,
    output logic             ovr,
    output logic [AW-1:0]    disp,
    output logic [CNT_W-1:0] nbytes
);

    seq_state_e        state;
    modrm_t            mb_q;
    sib_t              sib_q;
    logic              a32_q, ovr_q, sib_seen_q, rdy_q;
    logic [AW-1:0]     disp_q;
    logic [CNT_W-1:0]  dlen_q, left_q;
    logic [CNT_W-1:0]  dl;
    logic              acc, need_sib;
    logic [AW-1:0]     shifted;
    logic [5:0]        shamt;

    assign in_ready = rdy_q;
    assign acc      = in_valid && rdy_q;

    always_comb begin
        mb       = (state == S_MODRM) ? modrm_t'(in_byte) : mb_q;
        a32      = (state == S_MODRM) ? addr32 : a32_q;
        ovr      = (state == S_MODRM) ? seg_ovr : ovr_q;
        sb       = (state == S_SIB) ? sib_t'(in_byte) : sib_q;
        dl       = disp_bytes(a32, mb, sb);
        need_sib = sib_needed(a32, mb);
        shifted  = {in_byte, disp_q[AW-1:8]};
        shamt    = 6'(8 * (DMAX - int'(dlen_q)));
        disp     = (state == S_DISP) ? AW'($signed(shifted) >>> shamt) : '0;
        case (state)
            S_MODRM: fin = acc && !need_sib && (dl == '0);
            S_SIB:   fin = acc && (dl == '0);
            S_DISP:  fin = acc && (left_q == 3'd1);
            default: fin = 1'b0;
        endcase
        nbytes = 3'd1
               + ((state == S_SIB || (state == S_DISP && sib_seen_q)) ? 3'd1 : 3'd0)
               + ((state == S_DISP) ? dlen_q : 3'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_MODRM;
            mb_q       <= '0;
            sib_q      <= '0;
            a32_q      <= 1'b0;
            ovr_q      <= 1'b0;
            sib_seen_q <= 1'b0;
            disp_q     <= '0;
            dlen_q     <= '0;
            left_q     <= '0;
            rdy_q      <= 1'b0;
        end else begin
            rdy_q <= 1'b1;
            if (acc) begin
                case (state)
                    S_MODRM: begin
                        mb_q       <= mb;
                        a32_q      <= addr32;
                        ovr_q      <= seg_ovr;
                        sib_seen_q <= 1'b0;
                        disp_q     <= '0;
                        if (need_sib) begin
                            state <= S_SIB;
                        end else if (dl != '0) begin
                            state  <= S_DISP;
                            dlen_q <= dl;
                            left_q <= dl;
                        end
                    end
                    S_SIB: begin
                        sib_q      <= sb;
                        sib_seen_q <= 1'b1;
                        if (dl != '0) begin
                            state  <= S_DISP;
                            dlen_q <= dl;
                            left_q <= dl;
                        end else begin
                            state <= S_MODRM;
                        end
                    end
                    S_DISP: begin
                        disp_q <= shifted;
                        left_q <= left_q - 3'd1;
                        if (left_q == 3'd1) state <= S_MODRM;
                    end
                    default: state <= S_MODRM;
                endcase
            end
        end
    end

endmodule

// File: rtl/modrm_ea.sv
module modrm_ea
    import modrm_pkg::*;
(
    input  logic              a32,
    input  logic              ovr,
    input  logic [1:0]        md,
    input  logic [RIDX_W-1:0] rm,
    input  sib_t              sb,
    input  logic [AW-1:0]     disp,
    output logic [RIDX_W-1:0] idx_a,
    output logic [RIDX_W-1:0] idx_b,
    input  logic [AW-1:0]     val_a,
    input  logic [AW-1:0]     val_b,
    output logic              mem,
    output logic [AW-1:0]     ea,
    output logic              stack
);

    logic          use_a, use_b, stk;
    logic [1:0]    scale;
    logic [AW-1:0] term_a, term_b, sum32;
    logic [15:0]   sum16;

    always_comb begin
        use_a = 1'b0;
        use_b = 1'b0;
        stk   = 1'b0;
        scale = 2'd0;
        idx_a = R_AX;
        idx_b = R_AX;
        if (a32) begin
            if (rm == R_SP) begin
                idx_a = sb.base;
                idx_b = sb.idx;
                scale = sb.ss;
                use_a = !(sb.base == R_BP && md == 2'd0);
                use_b = (sb.idx != R_SP);
                stk   = (sb.base == R_SP);
            end else if (rm == R_BP && md == 2'd0) begin
                use_a = 1'b0;
            end else begin
                idx_a = rm;
                use_a = 1'b1;
                stk   = (rm == R_BP);
            end
        end else begin
            case (rm)
                3'd0: begin idx_a = R_BX; idx_b = R_SI; use_a = 1'b1; use_b = 1'b1; end
                3'd1: begin idx_a = R_BX; idx_b = R_DI; use_a = 1'b1; use_b = 1'b1; end
                3'd2: begin idx_a = R_BP; idx_b = R_SI; use_a = 1'b1; use_b = 1'b1; stk = 1'b1; end
                3'd3: begin idx_a = R_BP; idx_b = R_DI; use_a = 1'b1; use_b = 1'b1; stk = 1'b1; end
                3'd4: begin idx_a = R_SI; use_a = 1'b1; end
                3'd5: begin idx_a = R_DI; use_a = 1'b1; end
                3'd6: begin idx_a = R_BP; use_a = (md != 2'd0); stk = (md != 2'd0); end
                default: begin idx_a = R_BX; use_a = 1'b1; end
            endcase
        end
        term_a = use_a ? val_a : '0;
        term_b = use_b ? (val_b << scale) : '0;
        sum32  = term_a + term_b + disp;
        sum16  = term_a[15:0] + term_b[15:0] + disp[15:0];
        mem    = (md != 2'd3);
        ea     = !mem ? '0 : (a32 ? sum32 : {{(AW-16){1'b0}}, sum16});
        stack  = mem && stk && !ovr;
    end

endmodule

// File: rtl/modrm_decoder.sv
module modrm_decoder
    import modrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              addr32,
    input  logic              seg_ovr,
    output logic [RIDX_W-1:0] rd_idx_a,
    input  logic [AW-1:0]     rd_data_a,
    output logic [RIDX_W-1:0] rd_idx_b,
    input  logic [AW-1:0]     rd_data_b,
    output logic              done,
    output logic [RIDX_W-1:0] reg_num,
    output logic              is_mem,
    output logic [RIDX_W-1:0] rm_reg,
    output logic [AW-1:0]     eff_addr,
    output logic              use_stack,
    output logic [CNT_W-1:0]  bytes_used,
    output logic [1:0]        reg_byte_sel,
    output logic              reg_byte_hi,
    output logic [1:0]        rm_byte_sel,
    output logic              rm_byte_hi
);

    logic             fin, a32, ovr, mem_c, stk_c, res_a32;
    modrm_t           mb;
    sib_t             sb;
    logic [AW-1:0]    disp, ea_c;
    logic [CNT_W-1:0] nb_c;

    modrm_seq u_seq (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .in_ready(in_ready), .addr32(addr32), .seg_ovr(seg_ovr),
        .fin(fin), .mb(mb), .sb(sb), .a32(a32), .ovr(ovr),
        .disp(disp), .nbytes(nb_c)
    );

    modrm_ea u_ea (
        .a32(a32), .ovr(ovr), .md(mb.md), .rm(mb.rm), .sb(sb), .disp(disp),
        .idx_a(rd_idx_a), .idx_b(rd_idx_b), .val_a(rd_data_a), .val_b(rd_data_b),
        .mem(mem_c), .ea(ea_c), .stack(stk_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            reg_num    <= '0;
            rm_reg     <= '0;
            is_mem     <= 1'b0;
            eff_addr   <= '0;
            use_stack  <= 1'b0;
            bytes_used <= '0;
            res_a32    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                reg_num    <= mb.rf;
                rm_reg     <= mb.rm;
                is_mem     <= mem_c;
                eff_addr   <= ea_c;
                use_stack  <= stk_c;
                bytes_used <= nb_c;
                res_a32    <= a32;
            end
        end
    end

    assign reg_byte_sel = reg_num[1:0];
    assign reg_byte_hi  = reg_num[2];
    assign rm_byte_sel  = rm_reg[1:0];
    assign rm_byte_hi   = rm_reg[2];

endmodule

// File: rtl/modrm_decoder_chk.sv
module modrm_decoder_chk
    import modrm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             done,
    input logic             is_mem,
    input logic [AW-1:0]    eff_addr,
    input logic             use_stack,
    input logic [CNT_W-1:0] bytes_used,
    input logic             res_a32
);

    // R12
    done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_ready));

    // R12
    frozen_result_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(eff_addr) && $stable(bytes_used));

    // R1
    reg_form_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !is_mem) |-> (eff_addr == '0 && !use_stack && bytes_used == 3'd1));

    // R7
    stack_needs_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (done && use_stack) |-> is_mem);

    // R9
    narrow_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !res_a32) |-> (eff_addr[AW-1:16] == '0));

    // R11
    byte_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (bytes_used >= 3'd1 && bytes_used <= 3'd6));

endmodule

bind modrm_decoder modrm_decoder_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .done(done), .is_mem(is_mem), .eff_addr(eff_addr), .use_stack(use_stack),
    .bytes_used(bytes_used), .res_a32(res_a32)
);

// File: tb/modrm_decoder_bench.sv
module modrm_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  in_byte;
    logic        in_valid, in_ready, addr32, seg_ovr;
    logic [2:0]  rd_idx_a, rd_idx_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic        done, is_mem, use_stack, reg_byte_hi, rm_byte_hi;
    logic [2:0]  reg_num, rm_reg, bytes_used;
    logic [31:0] eff_addr;
    logic [1:0]  reg_byte_sel, rm_byte_sel;

    logic [31:0] regs [8];
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data_a = regs[rd_idx_a];
    assign rd_data_b = regs[rd_idx_b];

    modrm_decoder u_modrm_decoder (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
        .addr32(addr32), .seg_ovr(seg_ovr), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b), .done(done), .reg_num(reg_num),
        .is_mem(is_mem), .rm_reg(rm_reg), .eff_addr(eff_addr), .use_stack(use_stack),
        .bytes_used(bytes_used), .reg_byte_sel(reg_byte_sel), .reg_byte_hi(reg_byte_hi),
        .rm_byte_sel(rm_byte_sel), .rm_byte_hi(rm_byte_hi)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Send n bytes with gap idle cycles between them; sample at the negedge after the last.
    task automatic send(input logic a32, input logic ovr, input int n,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5,
                        input int gap);
        logic [7:0] q [6];
        q = '{b0, b1, b2, b3, b4, b5};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = q[i];
            addr32   = (i == 0) ? a32 : ~a32;
            seg_ovr  = (i == 0) ? ovr : ~ovr;
            @(posedge clk);
            if (i != n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    @(posedge clk);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_mem(input string req, input logic [31:0] ea,
                              input logic stk, input logic [2:0] nb);
        check({req, " done"}, 32'(done), 32'd1);
        check({req, " is_mem"}, 32'(is_mem), 32'd1);
        check({req, " addr"}, eff_addr, ea);
        check({req, " stack"}, 32'(use_stack), 32'(stk));
        check({req, " bytes"}, 32'(bytes_used), 32'(nb));
    endtask

    task automatic t_reset;
        check("R12 reset done", 32'(done), 32'd0);
        check("R12 reset addr", eff_addr, 32'd0);
        check("R12 ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_reg_form;
        send(1'b1, 1'b0, 1, 8'hD9, 0, 0, 0, 0, 0, 0);
        check("R1 is_mem", 32'(is_mem), 32'd0);
        check("R1 reg", 32'(reg_num), 32'd3);
        check("R1 rm", 32'(rm_reg), 32'd1);
        check("R1 bytes", 32'(bytes_used), 32'd1);
        check("R1 addr", eff_addr, 32'd0);
        check("R2 reg sel", 32'(reg_byte_sel), 32'd3);
        check("R2 reg hi", 32'(reg_byte_hi), 32'd0);
        send(1'b0, 1'b0, 1, 8'hE5, 0, 0, 0, 0, 0, 0);
        check("R2 reg sel hi", 32'(reg_byte_sel), 32'd0);
        check("R2 reg hi", 32'(reg_byte_hi), 32'd1);
        check("R2 rm sel", 32'(rm_byte_sel), 32'd1);
        check("R2 rm hi", 32'(rm_byte_hi), 32'd1);
        @(negedge clk);
        check("R12 pulse", 32'(done), 32'd0);
    endtask

    task automatic t_base32;
        send(1'b1, 1'b0, 2, 8'h43, 8'hF0, 0, 0, 0, 0, 0);
        expect_mem("R3 ebx-16", 32'h00003FF0, 1'b0, 3'd2);
        send(1'b1, 1'b0, 5, 8'h87, 8'h00, 8'hFF, 8'hFF, 8'hFF, 0, 2);
        expect_mem("R3 edi+disp32", 32'hFFFFFF60, 1'b0, 3'd5);
    endtask

    task automatic t_disp_only32;
        send(1'b1, 1'b0, 5, 8'h05, 8'h78, 8'h56, 8'h34, 8'h12, 0, 0);
        expect_mem("R4 R11 disp32", 32'h12345678, 1'b0, 3'd5);
    endtask

    task automatic t_sib;
        send(1'b1, 1'b0, 2, 8'h04, 8'h88, 0, 0, 0, 0, 0);
        expect_mem("R5 eax+ecx*4", 32'h00001800, 1'b0, 3'd2);
        send(1'b1, 1'b0, 3, 8'h44, 8'h24, 8'h10, 0, 0, 0, 1);
        expect_mem("R5 R7 esp no index", 32'h00008010, 1'b1, 3'd3);
        send(1'b1, 1'b0, 6, 8'h04, 8'hF5, 8'h00, 8'h01, 8'h00, 8'h00, 0);
        expect_mem("R6 disp+esi*8", 32'h00002900, 1'b0, 3'd6);
    endtask

    task automatic t_stack32;
        send(1'b1, 1'b0, 2, 8'h45, 8'h08, 0, 0, 0, 0, 0);
        expect_mem("R7 ebp+8", 32'hABC0F008, 1'b1, 3'd2);
        send(1'b1, 1'b1, 2, 8'h45, 8'h08, 0, 0, 0, 0, 0);
        expect_mem("R7 override", 32'hABC0F008, 1'b0, 3'd2);
    endtask

    task automatic t_table16;
        send(1'b0, 1'b0, 1, 8'h00, 0, 0, 0, 0, 0, 0);
        expect_mem("R8 bx+si", 32'h00004500, 1'b0, 3'd1);
        send(1'b0, 1'b0, 1, 8'h05, 0, 0, 0, 0, 0, 0);
        expect_mem("R8 di", 32'h00000060, 1'b0, 3'd1);
        send(1'b0, 1'b0, 2, 8'h42, 8'h80, 0, 0, 0, 0, 0);
        expect_mem("R8 R10 bp+si-128", 32'h0000F480, 1'b1, 3'd2);
    endtask

    task automatic t_disp16;
        send(1'b0, 1'b0, 3, 8'h06, 8'h34, 8'h12, 0, 0, 0, 1);
        expect_mem("R9 R11 disp16", 32'h00001234, 1'b0, 3'd3);
        send(1'b0, 1'b0, 2, 8'h46, 8'h02, 0, 0, 0, 0, 0);
        expect_mem("R10 bp+2", 32'h0000F002, 1'b1, 3'd2);
        send(1'b0, 1'b0, 3, 8'h87, 8'h00, 8'h20, 0, 0, 0, 0);
        expect_mem("R9 bx+0x2000", 32'h00006000, 1'b0, 3'd3);
        send(1'b0, 1'b0, 3, 8'h83, 8'h00, 8'h10, 0, 0, 0, 0);
        expect_mem("R9 R10 wrap", 32'h00000060, 1'b1, 3'd3);
        send(1'b0, 1'b1, 3, 8'h83, 8'h00, 8'h10, 0, 0, 0, 0);
        expect_mem("R10 override", 32'h00000060, 1'b0, 3'd3);
    endtask

    initial begin
        regs = '{32'h00001000, 32'h00000200, 32'h00000030, 32'h00004000,
                 32'h00008000, 32'hABC0F000, 32'h00000500, 32'h00000060};
        rst = 1'b1; in_valid = 1'b0; in_byte = '0; addr32 = 1'b0; seg_ovr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_reg_form;
        t_base32;
        t_disp_only32;
        t_sib;
        t_stack32;
        t_table16;
        t_disp16;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule